// File: doc/BRIEF.md
# Asymmetric SCL Phase Timer

This block times the serial clock for an I2C master's bit engine. A 32-bit divider word holds two counts: one sets how long SCL stays low and the other how long it stays high. Each count unit is worth eight input clocks. The two phases are set separately, so the duty cycle of SCL can be tuned to meet the bus's unequal low-time and high-time minimums.

While it is enabled the block runs low and high phases in turn. It marks four points in each bit with single-cycle ticks: SCL falling, the middle of the low phase (where SDA may change), SCL rising, and the middle of the high phase (where SDA is sampled). A further tick marks the last cycle of each full period so the bit engine can count bits. Software writes a new divider word through a simple load strobe. The word waits in a holding register and only takes effect at the start of the next low phase, so a bit already under way keeps its timing. When the enable is dropped the counters clear and SCL is left released (high).

Top module: `scl_phase_divider`

## Requirements
- R1: The divider word carries the low count in bits 15:0 and the high count in bits 31:16. The low phase lasts 8*(low+1) input clocks.
- R2: The high phase lasts 8*(high+1) input clocks, so a full period is 8*((low+1)+(high+1)) clocks. With both counts zero the period is 16 clocks.
- R3: `sclOut` is 0 for the whole low phase and 1 for the whole high phase. `phaseHigh` follows SCL while the block is running.
- R4: `tickSclFall` pulses in the first cycle of each low phase and `tickSclRise` pulses in the first cycle of each high phase.
- R5: `tickSdaChange` pulses 4*(low+1) cycles into the low phase. `tickSdaSample` pulses 4*(high+1) cycles into the high phase.
- R6: `tickPeriodEnd` pulses in the last cycle of each high phase, and the cycle after it begins a new low phase.
- R7: A word written with `divLoad` is used from the next low phase onward. The phases already begun keep the old counts. A load in the cycle before a low phase starts applies to that low phase.
- R8: Once the clock edge after `enable` falls has passed, `sclOut` is 1, `phaseHigh` is 0 and all ticks are 0. The first cycle after `enable` rises is the first cycle of a low phase.
- R9: After reset the stored divider word is zero, so enabling without a load gives the 16-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the timer; low clears it and releases SCL |
| divLoad | input | 1 | One-cycle strobe that captures `divValue` |
| divValue | input | 32 | Divider word: low count [15:0], high count [31:16] |
| sclOut | output | 1 | SCL level (1 = released) |
| phaseHigh | output | 1 | High phase in progress |
| tickSdaChange | output | 1 | Middle of the low phase |
| tickSclRise | output | 1 | First cycle of the high phase |
| tickSdaSample | output | 1 | Middle of the high phase |
| tickSclFall | output | 1 | First cycle of the low phase |
| tickPeriodEnd | output | 1 | Last cycle of the full period |

## Verification
The bench sweeps every pair of low and high counts from 0 to 3, plus some lopsided pairs, and compares each output on every cycle against a period model worked out arithmetically. Counts of zero catch off-by-one errors in the phase lengths and in the midpoint offsets, which would make ticks drift by a cycle or collide. Loads made partway through a low phase and partway through a high phase catch a design that switches counts at once and cuts a bit short. A load in the final cycle of a period catches a design that misses the boundary by one bit. Tests also drop the enable in the middle of a run and check that SCL is released and that the timer restarts cleanly with a fresh low phase.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  // Commands from the phase controller to the counting datapath
  typedef struct packed {
    logic clearPos;   // restart the position counter at zero
    logic latchDiv;   // copy the held divider word into the active counts
    logic selHigh;    // compare against the high-phase count
  } div_ctrl_t;

endpackage

// File: rtl/scl_div_datapath.sv
module scl_div_datapath
  import scl_div_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int UNIT  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               divLoad,
  input  logic [2*CNT_W-1:0] divValue,
  input  div_ctrl_t          ctrl,
  output logic               posZero,
  output logic               posMid,
  output logic               posLast
);
  localparam int UNIT_W = $clog2(UNIT);
  localparam int POS_W  = CNT_W + UNIT_W;

  logic [CNT_W-1:0] pendLo, pendHi, actLo, actHi;
  logic [CNT_W-1:0] nextLo, nextHi, curCnt;
  logic [CNT_W:0]   cntPlus;
  logic [POS_W-1:0] pos, lastPos, midPos;

  // Held word, with a same-cycle load bypass so that it lands on a phase start
  assign nextLo = divLoad ? divValue[CNT_W-1:0]       : pendLo;
  assign nextHi = divLoad ? divValue[2*CNT_W-1:CNT_W] : pendHi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendLo <= '0;
      pendHi <= '0;
    end else begin
      pendLo <= nextLo;
      pendHi <= nextHi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actLo <= '0;
      actHi <= '0;
    end else if (ctrl.latchDiv) begin
      actLo <= nextLo;
      actHi <= nextHi;
    end
  end

  // Phase length is UNIT*(count+1); the last position is that minus one
  assign curCnt  = ctrl.selHigh ? actHi : actLo;
  assign cntPlus = {1'b0, curCnt} + {{CNT_W{1'b0}}, 1'b1};
  assign lastPos = {curCnt, {UNIT_W{1'b1}}};
  assign midPos  = POS_W'(cntPlus) << (UNIT_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pos <= '0;
    else if (ctrl.clearPos) pos <= '0;
    else                    pos <= pos + POS_W'(1);
  end

  assign posZero = (pos == '0);
  assign posMid  = (pos == midPos);
  assign posLast = (pos == lastPos);

endmodule

// File: rtl/scl_div_ctrl.sv
module scl_div_ctrl
  import scl_div_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      posZero,
  input  logic      posMid,
  input  logic      posLast,
  output div_ctrl_t ctrl,
  output logic      sclOut,
  output logic      phaseHigh,
  output logic      tickSdaChange,
  output logic      tickSclRise,
  output logic      tickSdaSample,
  output logic      tickSclFall,
  output logic      tickPeriodEnd
);
  logic running, inHigh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      inHigh  <= 1'b0;
    end else if (!enable) begin
      running <= 1'b0;
      inHigh  <= 1'b0;
    end else if (!running) begin
      running <= 1'b1;
      inHigh  <= 1'b0;
    end else if (posLast) begin
      inHigh  <= ~inHigh;
    end
  end

  always_comb begin
    ctrl.clearPos = !enable || !running || posLast;
    ctrl.latchDiv = enable && (!running || (posLast && inHigh));
    ctrl.selHigh  = inHigh;
  end

  assign phaseHigh     = running && inHigh;
  assign sclOut        = !running || inHigh;
  assign tickSclFall   = running && !inHigh && posZero;
  assign tickSdaChange = running && !inHigh && posMid;
  assign tickSclRise   = running &&  inHigh && posZero;
  assign tickSdaSample = running &&  inHigh && posMid;
  assign tickPeriodEnd = running &&  inHigh && posLast;

endmodule

// File: rtl/scl_phase_divider.sv
module scl_phase_divider
  import scl_div_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int UNIT  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               divLoad,
  input  logic [2*CNT_W-1:0] divValue,
  output logic               sclOut,
  output logic               phaseHigh,
  output logic               tickSdaChange,
  output logic               tickSclRise,
  output logic               tickSdaSample,
  output logic               tickSclFall,
  output logic               tickPeriodEnd
);
  div_ctrl_t ctrl;
  logic posZero, posMid, posLast;

  scl_div_datapath #(.CNT_W(CNT_W), .UNIT(UNIT)) dp_i (
    .clk(clk), .rst_n(rst_n), .divLoad(divLoad), .divValue(divValue),
    .ctrl(ctrl), .posZero(posZero), .posMid(posMid), .posLast(posLast)
  );

  scl_div_ctrl ctl_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .posZero(posZero), .posMid(posMid), .posLast(posLast),
    .ctrl(ctrl), .sclOut(sclOut), .phaseHigh(phaseHigh),
    .tickSdaChange(tickSdaChange), .tickSclRise(tickSclRise),
    .tickSdaSample(tickSdaSample), .tickSclFall(tickSclFall),
    .tickPeriodEnd(tickPeriodEnd)
  );

endmodule

// File: rtl/scl_div_checker.sv
module scl_div_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sclOut,
  input logic phaseHigh,
  input logic tickSdaChange,
  input logic tickSclRise,
  input logic tickSdaSample,
  input logic tickSclFall,
  input logic tickPeriodEnd
);
  // R8: a dropped enable leaves SCL released after the next edge
  p_released_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sclOut && !phaseHigh && !tickSclFall && !tickSclRise));

  // R6: the end of a period hands over to a new low phase
  p_end_then_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tickPeriodEnd && enable) |=> tickSclFall);

  // R4: edge ticks agree with the SCL level
  p_rise_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tickSclRise |-> (sclOut && phaseHigh));
  p_fall_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tickSclFall |-> (!sclOut && !phaseHigh));

  // R5: the timing points of one bit never coincide
  p_ticks_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tickSdaChange, tickSclRise, tickSdaSample, tickSclFall, tickPeriodEnd}));

  // R3: SCL only moves at a marked edge or when the enable changes
  p_scl_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !tickSclRise && !tickSclFall) |-> $stable(sclOut));
endmodule

bind scl_phase_divider scl_div_checker chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sclOut(sclOut),
  .phaseHigh(phaseHigh), .tickSdaChange(tickSdaChange),
  .tickSclRise(tickSclRise), .tickSdaSample(tickSdaSample),
  .tickSclFall(tickSclFall), .tickPeriodEnd(tickPeriodEnd)
);

// File: tb/scl_phase_divider_tb.sv
module scl_phase_divider_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic divLoad = 1'b0;
  logic [31:0] divValue = '0;
  logic sclOut, phaseHigh, tickSdaChange, tickSclRise, tickSdaSample;
  logic tickSclFall, tickPeriodEnd;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  scl_phase_divider dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .divLoad(divLoad),
    .divValue(divValue), .sclOut(sclOut), .phaseHigh(phaseHigh),
    .tickSdaChange(tickSdaChange), .tickSclRise(tickSclRise),
    .tickSdaSample(tickSdaSample), .tickSclFall(tickSclFall),
    .tickPeriodEnd(tickPeriodEnd)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0b expected %0b", tag, k, act, exp);
    end
  endtask

  // Runs n cycles from an enable edge. The bench holds its own model of the
  // held and active counts. A load of (nLo,nHi) is driven before edge kLoad (-1 = none).
  task automatic runSeq(input int preLo, input int preHi, input bit doPre,
                        input int n, input int kLoad, input int nLo, input int nHi);
    int pLo, pHi, aLo, aHi, m, lw, hw;
    @(negedge clk);
    enable = 1'b0;
    if (doPre) begin
      // R1: low count in bits 15:0, high count in bits 31:16
      divLoad = 1'b1;
      divValue = {preHi[15:0], preLo[15:0]};
      pLo = preLo; pHi = preHi;
    end
    @(negedge clk);
    divLoad = 1'b0;
    if (!doPre) begin pLo = 0; pHi = 0; end  // R9 reset value
    aLo = pLo; aHi = pHi; m = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      enable = 1'b1;
      divLoad = (k == kLoad);
      divValue = {nHi[15:0], nLo[15:0]};
      if (k == kLoad) begin pLo = nLo; pHi = nHi; end
      @(posedge clk);
      #1;
      if (m == 0) begin aLo = pLo; aHi = pHi; end  // R7 latch at low start
      lw = 8 * (aLo + 1);  // R1
      hw = 8 * (aHi + 1);  // R2
      chk(sclOut,        (m >= lw),               "R3 sclOut", k);
      chk(phaseHigh,     (m >= lw),               "R3 phaseHigh", k);
      chk(tickSclFall,   (m == 0),                "R4 tickSclFall", k);
      chk(tickSclRise,   (m == lw),               "R4 tickSclRise", k);
      chk(tickSdaChange, (m == lw / 2),           "R5 tickSdaChange", k);
      chk(tickSdaSample, (m == lw + hw / 2),      "R5 tickSdaSample", k);
      chk(tickPeriodEnd, (m == lw + hw - 1),      "R6 tickPeriodEnd", k);
      m++;
      if (m == lw + hw) m = 0;
    end
    @(negedge clk);
    divLoad = 1'b0;
  endtask

  task automatic checkIdle(input string tag);
    @(posedge clk);
    #1;
    chk(sclOut, 1'b1, {tag, " sclOut"}, 0);
    chk(phaseHigh, 1'b0, {tag, " phaseHigh"}, 0);
    chk(tickSclFall | tickSclRise | tickSdaChange | tickSdaSample | tickPeriodEnd,
        1'b0, {tag, " ticks"}, 0);
  endtask

  initial begin : watchdog
    #1_200_000;
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state: released and quiet
    chk(sclOut, 1'b1, "R8 reset sclOut", 0);
    chk(tickSclFall | tickPeriodEnd, 1'b0, "R8 reset ticks", 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: no load after reset, so the 16-clock period applies (R2)
    runSeq(0, 0, 1'b0, 40, -1, 0, 0);

    // R1 R2 sweep over small counts
    for (int lo = 0; lo < 4; lo++)
      for (int hi = 0; hi < 4; hi++)
        runSeq(lo, hi, 1'b1, 2 * 8 * (lo + hi + 2) + 3, -1, 0, 0);

    // lopsided pairs
    runSeq(20, 1, 1'b1, 2 * 8 * 23, -1, 0, 0);
    runSeq(0, 13, 1'b1, 2 * 8 * 15, -1, 0, 0);

    // R7: load partway through the high phase (old counts finish the bit)
    runSeq(2, 1, 1'b1, 200, 30, 0, 4);
    // R7: load partway through the low phase
    runSeq(3, 2, 1'b1, 200, 5, 1, 0);
    // R7: load on the edge that starts a new low phase (period 40, edge 40)
    runSeq(1, 2, 1'b1, 200, 40, 3, 0);
    // R7: load together with the enable edge
    runSeq(2, 2, 1'b1, 120, 0, 0, 1);

    // R8: drop enable partway through, SCL released after one edge
    runSeq(1, 1, 1'b1, 21, -1, 0, 0);
    @(negedge clk);
    enable = 1'b0;
    checkIdle("R8 disabled");
    checkIdle("R8 still disabled");
    // R8: restart begins with a fresh low phase, held word kept
    runSeq(0, 0, 1'b0, 1, -1, 0, 0);
    runSeq(1, 3, 1'b1, 100, -1, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule